// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block computes the next fetch address for a five-stage in-order pipeline. It settles conditional branches and unconditional jumps while the instruction sits in the decode stage. A conditional branch tests only whether one source register is zero or nonzero. That test, together with a dedicated target adder, fits in decode, so a taken branch costs one fetch slot instead of three.

The decode logic supplies the instruction's fields and the forwarded value of its source register. The unit returns the address that the PC register loads at the next edge and a redirect strobe. It also returns a flush strobe that turns the newly captured IF/ID contents into a no-operation.

A parameter selects what happens to the instruction fetched behind the branch. In delayed mode it always executes as a delay slot. In squash mode fetch assumes fall-through, and that successor is flushed when control transfers. While the pipeline is stalled, the unit keeps the decision it made on the first stalled cycle and releases it on the cycle the stall ends.

Top module: `brResolveUnit`

## Requirements
- R1: With neither isBranch nor isJump high (including during and right after reset), redirect and flushIfId are 0 and nextPc equals fetchPcPlus4.
- R2: A branch with brOnNonZero = 0 is taken exactly when srcValue is all zeros.
- R3: A branch with brOnNonZero = 1 is taken exactly when srcValue is not all zeros.
- R4: The branch target is idPcPlus4 plus the 16-bit immediate, sign-extended and shifted left by 2. A negative immediate moves the target backwards.
- R5: A jump is always taken. Its target takes bits 31:28 from idPcPlus4, then the 26-bit jump field, then two zero bits.
- R6: An unstalled taken decision raises redirect and drives nextPc to the target in the same cycle as the decode inputs, with no register in the path. A not-taken branch leaves redirect at 0 and nextPc at fetchPcPlus4.
- R7: In squash mode (DELAYED = 0), flushIfId equals redirect on every cycle.
- R8: In delayed mode (DELAYED = 1), flushIfId is never asserted and redirect behaves as in squash mode.
- R9: While stall is high, redirect and flushIfId are 0.
- R10: The decision and target present on the first stalled cycle are kept. On the cycle stall falls, redirect and nextPc reflect that kept decision even if srcValue or the immediate changed during the stall.
- R11: From the second stalled cycle onward, a kept taken decision holds nextPc constant until the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Pipeline freeze; the PC and IF/ID do not load |
| isBranch | input | 1 | Decode holds a conditional branch |
| brOnNonZero | input | 1 | Branch sense: 0 = taken on zero, 1 = taken on nonzero |
| isJump | input | 1 | Decode holds an unconditional jump |
| immField | input | 16 | Branch displacement in words |
| jumpField | input | 26 | Jump target word index |
| srcValue | input | 32 | Forwarded value of the branch source register |
| idPcPlus4 | input | 32 | Address following the instruction in decode |
| fetchPcPlus4 | input | 32 | Sequential address from the fetch stage |
| nextPc | output | 32 | Address the PC register loads at the next edge |
| redirect | output | 1 | Control transfer is taking effect this cycle |
| flushIfId | output | 1 | Replace the IF/ID capture with a no-operation |

## Verification
The embedded assertions watch, on every cycle, that no redirect or flush leaks out while stalled. They also check that delayed mode never flushes, that a flush never appears without a redirect, and that a kept target does not drift during a long stall. Only the bench scenarios can show that the zero and nonzero senses pick the right outcome and that the adder and the jump concatenation produce the right addresses, including negative displacements. The bench also shows that a decision made before a stall survives changes in the forwarded value and is released on the correct cycle.

// File: rtl/brResolvePkg.sv
package brResolvePkg;

  // Strobes from the control side to the address datapath
  typedef struct packed {
    logic selJump;      // live target comes from the jump field
    logic captureHold;  // latch live target into the hold register
    logic useHold;      // present the held target instead of the live one
    logic steerTarget;  // nextPc takes the target instead of fall-through
  } brStrobes_t;

endpackage

// File: rtl/brDatapath.sv
module brDatapath
  import brResolvePkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int JUMP_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  brStrobes_t        str,
  input  logic [IMM_W-1:0]  immField,
  input  logic [JUMP_W-1:0] jumpField,
  input  logic [DATA_W-1:0] srcValue,
  input  logic [ADDR_W-1:0] idPcPlus4,
  input  logic [ADDR_W-1:0] fetchPcPlus4,
  output logic              srcIsZero,
  output logic [ADDR_W-1:0] nextPc
);

  localparam int SHIFT  = 2;
  localparam int EXT_W  = ADDR_W - IMM_W - SHIFT;
  localparam int HIGH_W = ADDR_W - JUMP_W - SHIFT;

  logic [ADDR_W-1:0] branchOffset;
  logic [ADDR_W-1:0] branchTarget;
  logic [ADDR_W-1:0] jumpTarget;
  logic [ADDR_W-1:0] liveTarget;
  logic [ADDR_W-1:0] holdTarget;
  logic [ADDR_W-1:0] chosenTarget;

  // Zero detector on the forwarded source operand
  assign srcIsZero = (srcValue == '0);

  // Dedicated target adder in decode
  assign branchOffset = {{EXT_W{immField[IMM_W-1]}}, immField, {SHIFT{1'b0}}};
  assign branchTarget = idPcPlus4 + branchOffset;

  // Region-relative jump target
  assign jumpTarget = {idPcPlus4[ADDR_W-1 -: HIGH_W], jumpField, {SHIFT{1'b0}}};

  assign liveTarget = str.selJump ? jumpTarget : branchTarget;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdTarget <= '0;
    end else if (str.captureHold) begin
      holdTarget <= liveTarget;
    end
  end

  assign chosenTarget = str.useHold ? holdTarget : liveTarget;
  assign nextPc       = str.steerTarget ? chosenTarget : fetchPcPlus4;

  AST_HELD_PC_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (stall && $past(stall) && str.useHold && str.steerTarget) |-> $stable(nextPc)); // R11

endmodule

// File: rtl/brControl.sv
module brControl
  import brResolvePkg::*;
#(
  parameter bit DELAYED = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stall,
  input  logic       isBranch,
  input  logic       brOnNonZero,
  input  logic       isJump,
  input  logic       srcIsZero,
  output brStrobes_t str,
  output logic       redirect,
  output logic       flushIfId
);

  logic condMet;
  logic liveTake;
  logic holdValid;
  logic holdTake;
  logic effTake;

  assign condMet  = isBranch && (brOnNonZero ? !srcIsZero : srcIsZero);
  assign liveTake = isJump || condMet;

  // Keep the decision from the first stalled cycle until the stall ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdTake  <= 1'b0;
    end else if (!stall) begin
      holdValid <= 1'b0;
      holdTake  <= 1'b0;
    end else if (!holdValid) begin
      holdValid <= 1'b1;
      holdTake  <= liveTake;
    end
  end

  assign effTake = holdValid ? holdTake : liveTake;

  always_comb begin
    str.selJump     = isJump;
    str.captureHold = stall && !holdValid;
    str.useHold     = holdValid;
    str.steerTarget = effTake;
  end

  assign redirect = effTake && !stall;

  generate
    if (DELAYED) begin : gDelaySlot
      assign flushIfId = 1'b0;
    end else begin : gSquash
      assign flushIfId = redirect;
    end
  endgenerate

  AST_NO_REDIRECT_IN_STALL: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (!redirect && !flushIfId)); // R9

  if (DELAYED) begin : gDelayChk
    AST_DELAYED_NEVER_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
      !flushIfId); // R8
  end

  AST_FLUSH_NEEDS_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    flushIfId |-> redirect); // R7

  AST_HOLD_ONLY_IN_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (holdValid && !$past(stall)) |-> 1'b0); // R10

endmodule

// File: rtl/brResolveUnit.sv
module brResolveUnit
  import brResolvePkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int JUMP_W  = 26,
  parameter bit DELAYED = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  logic              isBranch,
  input  logic              brOnNonZero,
  input  logic              isJump,
  input  logic [IMM_W-1:0]  immField,
  input  logic [JUMP_W-1:0] jumpField,
  input  logic [DATA_W-1:0] srcValue,
  input  logic [ADDR_W-1:0] idPcPlus4,
  input  logic [ADDR_W-1:0] fetchPcPlus4,
  output logic [ADDR_W-1:0] nextPc,
  output logic              redirect,
  output logic              flushIfId
);

  brStrobes_t ctlStr;
  logic       srcIsZero;

  brControl #(
    .DELAYED (DELAYED)
  ) control_i (
    .clk         (clk),
    .rstN        (rstN),
    .stall       (stall),
    .isBranch    (isBranch),
    .brOnNonZero (brOnNonZero),
    .isJump      (isJump),
    .srcIsZero   (srcIsZero),
    .str         (ctlStr),
    .redirect    (redirect),
    .flushIfId   (flushIfId)
  );

  brDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .JUMP_W (JUMP_W)
  ) datapath_i (
    .clk          (clk),
    .rstN         (rstN),
    .stall        (stall),
    .str          (ctlStr),
    .immField     (immField),
    .jumpField    (jumpField),
    .srcValue     (srcValue),
    .idPcPlus4    (idPcPlus4),
    .fetchPcPlus4 (fetchPcPlus4),
    .srcIsZero    (srcIsZero),
    .nextPc       (nextPc)
  );

  AST_IDLE_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (!isBranch && !isJump && !stall) |-> (!redirect && nextPc == fetchPcPlus4)); // R1

endmodule

// File: tb/brResolveUnit_tb_top.sv
`timescale 1ns/1ps
module brResolveUnit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stall = 1'b0;
  logic        isBranch = 1'b0;
  logic        brOnNonZero = 1'b0;
  logic        isJump = 1'b0;
  logic [15:0] immField = '0;
  logic [25:0] jumpField = '0;
  logic [31:0] srcValue = '0;
  logic [31:0] idPcPlus4 = 32'h0000_1004;
  logic [31:0] fetchPcPlus4 = 32'h0000_1008;
  logic [31:0] nextPc, nextPcD;
  logic        redirect, redirectD, flushIfId, flushIfIdD;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  brResolveUnit #(.DELAYED(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .stall(stall), .isBranch(isBranch),
    .brOnNonZero(brOnNonZero), .isJump(isJump), .immField(immField),
    .jumpField(jumpField), .srcValue(srcValue), .idPcPlus4(idPcPlus4),
    .fetchPcPlus4(fetchPcPlus4), .nextPc(nextPc), .redirect(redirect),
    .flushIfId(flushIfId)
  );

  brResolveUnit #(.DELAYED(1'b1)) dutDly_i (
    .clk(clk), .rstN(rstN), .stall(stall), .isBranch(isBranch),
    .brOnNonZero(brOnNonZero), .isJump(isJump), .immField(immField),
    .jumpField(jumpField), .srcValue(srcValue), .idPcPlus4(idPcPlus4),
    .fetchPcPlus4(fetchPcPlus4), .nextPc(nextPcD), .redirect(redirectD),
    .flushIfId(flushIfIdD)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] brTarget(input logic [31:0] pc4, input logic [15:0] imm);
    return pc4 + {{14{imm[15]}}, imm, 2'b00};
  endfunction

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic idle();
    isBranch = 0; isJump = 0; stall = 0; brOnNonZero = 0;
  endtask

  // Check both instances at the current point (after inputs settle)
  task automatic expectBoth(input string req, input bit take, input logic [31:0] target);
    logic [31:0] expPc;
    expPc = take ? target : fetchPcPlus4;
    #1;
    chk({req, " squash redirect"}, {31'b0, redirect}, {31'b0, take});
    chk({req, " squash nextPc"}, nextPc, expPc);
    chk({req, " squash flush (R7)"}, {31'b0, flushIfId}, {31'b0, take});
    chk({req, " delayed redirect"}, {31'b0, redirectD}, {31'b0, take});
    chk({req, " delayed nextPc"}, nextPcD, expPc);
    chk({req, " delayed flush (R8)"}, {31'b0, flushIfIdD}, 32'h0);
  endtask

  task automatic testReset();
    // R1: idle during reset
    #1;
    expectBoth("R1 reset", 1'b0, 32'h0);
    settle(); settle();
    rstN = 1'b1;
    settle();
    expectBoth("R1 after reset", 1'b0, 32'h0);
  endtask

  task automatic testBeqz();
    // R2 R4 R6: taken on zero, positive and negative displacement
    settle();
    idle(); isBranch = 1; srcValue = 0; immField = 16'h0010;
    expectBoth("R2 zero taken", 1'b1, brTarget(idPcPlus4, 16'h0010));
    settle();
    srcValue = 32'h0000_0100;
    expectBoth("R2 nonzero not taken", 1'b0, 32'h0);
    settle();
    srcValue = 0; immField = 16'hFFF0; idPcPlus4 = 32'h0000_2000;
    expectBoth("R4 negative offset", 1'b1, brTarget(32'h0000_2000, 16'hFFF0));
    chk("R4 negative target value", nextPc, 32'h0000_1FC0);
    settle(); idle();
    expectBoth("R1 back to idle", 1'b0, 32'h0);
  endtask

  task automatic testBnez();
    // R3: taken on nonzero, including only the top bit set
    settle();
    idle(); isBranch = 1; brOnNonZero = 1; srcValue = 32'h8000_0000;
    immField = 16'h0003; idPcPlus4 = 32'h0000_3000;
    expectBoth("R3 nonzero taken", 1'b1, brTarget(32'h0000_3000, 16'h0003));
    settle();
    srcValue = 0;
    expectBoth("R3 zero not taken", 1'b0, 32'h0);
    settle(); idle();
  endtask

  task automatic testJump();
    // R5: unconditional, ignores srcValue and sense
    settle();
    idle(); isJump = 1; jumpField = 26'h2AB_CDEF; idPcPlus4 = 32'hA000_0040;
    srcValue = 32'h1234;
    expectBoth("R5 jump", 1'b1, {4'hA, 26'h2AB_CDEF, 2'b00});
    settle();
    srcValue = 0; brOnNonZero = 1;
    expectBoth("R5 jump any operand", 1'b1, {4'hA, 26'h2AB_CDEF, 2'b00});
    settle(); idle();
  endtask

  task automatic testStallTaken();
    logic [31:0] tgt;
    settle();
    idle(); isBranch = 1; srcValue = 0; immField = 16'h0020; idPcPlus4 = 32'h0000_4000;
    tgt = brTarget(32'h0000_4000, 16'h0020);
    stall = 1;
    #1;
    chk("R9 no redirect in stall", {31'b0, redirect}, 32'h0);
    chk("R9 no flush in stall", {31'b0, flushIfId}, 32'h0);
    settle();
    // operand and immediate change while stalled
    srcValue = 32'h55; immField = 16'h0001;
    #1;
    chk("R11 held target", nextPc, tgt);
    chk("R9 still no redirect", {31'b0, redirect}, 32'h0);
    settle();
    #1;
    chk("R11 held target later", nextPc, tgt);
    settle();
    stall = 0;
    expectBoth("R10 release taken", 1'b1, tgt);
    settle(); idle();
    expectBoth("R10 hold cleared", 1'b0, 32'h0);
  endtask

  task automatic testStallNotTaken();
    settle();
    idle(); isBranch = 1; srcValue = 32'h7; immField = 16'h0008; idPcPlus4 = 32'h0000_5000;
    stall = 1;
    settle();
    srcValue = 0;  // would now be taken
    #1;
    chk("R9 stalled not-taken redirect", {31'b0, redirect}, 32'h0);
    settle();
    stall = 0;
    expectBoth("R10 release keeps not-taken", 1'b0, 32'h0);
    settle();
    // hold released: live decision applies again
    expectBoth("R6 live after release", 1'b1, brTarget(32'h0000_5000, 16'h0008));
    settle(); idle();
  endtask

  initial begin
    testReset();
    testBeqz();
    testBnez();
    testJump();
    testStallTaken();
    testStallNotTaken();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule